// File: doc/BRIEF.md
# Synchronous Burst SRAM with Address Sequencer

This block is a synthesizable model of a flow-through synchronous burst SRAM. It has a word width of four 8-bit byte lanes, separate write-data and read-data paths, and an address depth set by a parameter. Every control and data input is sampled on the rising clock edge. An access begins when one of two address strobes is asserted. The processor strobe only counts while the primary select is active. The controller strobe always counts. The starting address and the select state are held in registers. A 2-bit burst counter then generates the next three word offsets. The order is either linear or interleaved (XOR), picked by a mode input.

Reads are flow-through. The word at a captured address is on the read port after the same edge that captured it, and each advanced address gives a new word after its own edge. A burst therefore takes one cycle for the first word and one cycle for each of the next three. Writes are masked per lane. A global write stores all lanes. A lane-write enable stores only the lanes whose individual enables are low. The read-drive output depends combinationally on the output-enable and sleep inputs. While sleep is high the array cannot be loaded or written.

Top module: `burst_sram`

## Requirements
- R1: When `strobe_ctl_n` is low, or when `strobe_cpu_n` and `sel_n` are both low, the edge captures `addr_in` with a burst count of 0. For a read, the captured word is on `rd_data` with `rd_drive` high after that same edge. The processor strobe has priority.
- R2: A low `strobe_cpu_n` with `sel_n` high does not start an access. With `strobe_ctl_n` and `step_n` high, the current address and data stay unchanged.
- R3: An access is selected only when `sel_n`=0, `sel_p`=1 and `sel2_n`=0 at the start edge. A deselected access writes nothing and keeps `rd_drive` low.
- R4: With `order_xor`=0, the word offset (address bits 1:0) at burst count k is (start + k) mod 4. The upper address bits stay fixed.
- R5: With `order_xor`=1, the word offset at burst count k is start XOR k.
- R6: The burst count advances on an edge only when `step_n` is low. Otherwise the same address is accessed again.
- R7: With `all_wr_n`=0, all four lanes are written. Otherwise, with `lane_wr_en_n`=0, lane i (data bits 8i+7:8i) is written when `lane_n[i]`=0. Otherwise the cycle is a read.
- R8: A start made through the processor strobe is always a read, whatever the write inputs are.
- R9: `rd_drive` falls at once, with no clock edge, while `out_en_n` is high.
- R10: While `sleep` is high, nothing is written or loaded and `rd_drive` is low. After `sleep` falls, `rd_drive` stays low until a new read access starts.
- R11: After reset `rd_drive` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_in | input | ADDR_W | Word address |
| sel_n | input | 1 | Primary select, active low |
| sel_p | input | 1 | Second select, active high |
| sel2_n | input | 1 | Third select, active low |
| strobe_cpu_n | input | 1 | Processor address strobe, active low |
| strobe_ctl_n | input | 1 | Controller address strobe, active low |
| step_n | input | 1 | Burst advance, active low |
| order_xor | input | 1 | 1 = interleaved order, 0 = linear order |
| all_wr_n | input | 1 | Global write, active low |
| lane_wr_en_n | input | 1 | Lane-write enable, active low |
| lane_n | input | LANES | Per-lane write enables, active low |
| wr_data | input | LANES*LANE_W | Write data |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep request, active high |
| rd_data | output | LANES*LANE_W | Read data |
| rd_drive | output | 1 | High when rd_data should drive the bus |

## Verification
The hardest situation to reach is a burst whose state must survive something that looks like a new start but is not: a processor strobe with the primary select inactive in the middle of a burst, or a sleep period followed by wake-up. The directed part of the bench builds these on purpose. It opens a burst, inserts the ignored strobe or a stall, and then resumes. It also walks both burst orders from all four start offsets over a pre-filled array so that each offset sequence can be seen in the data. Random cycles then combine the strobes, the select levels, stalls and partial writes, with sleep kept rare.

// File: rtl/burst_sram_pkg.sv
package burst_sram_pkg;
  typedef enum logic {ORD_LINEAR = 1'b0, ORD_XOR = 1'b1} order_e;

  // word offset within a 4-word burst for count k
  function automatic logic [1:0] burst_off(input logic [1:0] start,
                                           input logic [1:0] k,
                                           input order_e ord);
    logic [1:0] r;
    if (ord == ORD_XOR) r = start ^ k;
    else                r = start + k;
    return r;
  endfunction
endpackage

// File: rtl/bsr_addr_seq.sv
module bsr_addr_seq
  import burst_sram_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              sel_n,
  input  logic              sel_p,
  input  logic              sel2_n,
  input  logic              strobe_cpu_n,
  input  logic              strobe_ctl_n,
  input  logic              step_n,
  input  logic              order_xor,
  input  logic              sleep,
  output logic              load,
  output logic              load_cpu,
  output logic              sel_nx,
  output logic              sel_q,
  output logic [ADDR_W-1:0] addr_nx,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int HI_W = ADDR_W - 2;

  logic [HI_W-1:0] hi_q, hi_nx;
  logic [1:0]      s_q, s_nx, k_q, k_nx;
  logic            go_cpu, go_ctl;

  assign go_cpu   = !strobe_cpu_n && !sel_n && !sleep;
  assign go_ctl   = !strobe_ctl_n && !go_cpu && !sleep;
  assign load     = go_cpu || go_ctl;
  assign load_cpu = go_cpu;

  always_comb begin
    hi_nx  = hi_q;
    s_nx   = s_q;
    k_nx   = k_q;
    sel_nx = sel_q;
    if (sleep) begin
      sel_nx = 1'b0;
    end else if (load) begin
      hi_nx  = addr_in[ADDR_W-1:2];
      s_nx   = addr_in[1:0];
      k_nx   = 2'd0;
      sel_nx = !sel_n && sel_p && !sel2_n;
    end else if (sel_q && !step_n) begin
      k_nx = k_q + 2'd1;
    end
    addr_nx = {hi_nx, burst_off(s_nx, k_nx, order_e'(order_xor))};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_q     <= '0;
      s_q      <= '0;
      k_q      <= '0;
      sel_q    <= 1'b0;
      cur_addr <= '0;
    end else begin
      hi_q     <= hi_nx;
      s_q      <= s_nx;
      k_q      <= k_nx;
      sel_q    <= sel_nx;
      cur_addr <= addr_nx;
    end
  end
endmodule

// File: rtl/bsr_lane_decode.sv
module bsr_lane_decode #(
  parameter int LANES = 4
) (
  input  logic             all_wr_n,
  input  logic             lane_wr_en_n,
  input  logic [LANES-1:0] lane_n,
  output logic [LANES-1:0] mask
);
  always_comb begin
    if (!all_wr_n)          mask = '1;
    else if (!lane_wr_en_n) mask = ~lane_n;
    else                    mask = '0;
  end
endmodule

// File: rtl/bsr_array.sv
module bsr_array #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [LANES-1:0]        we,
  input  logic [LANES*LANE_W-1:0] wd,
  output logic [LANES*LANE_W-1:0] rd
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (we[i]) mem[addr] <= wd[i*LANE_W +: LANE_W];
      rd[i*LANE_W +: LANE_W] <= mem[addr];
    end
  end
endmodule

// File: rtl/burst_sram.sv
module burst_sram #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       addr_in,
  input  logic                    sel_n,
  input  logic                    sel_p,
  input  logic                    sel2_n,
  input  logic                    strobe_cpu_n,
  input  logic                    strobe_ctl_n,
  input  logic                    step_n,
  input  logic                    order_xor,
  input  logic                    all_wr_n,
  input  logic                    lane_wr_en_n,
  input  logic [LANES-1:0]        lane_n,
  input  logic [LANES*LANE_W-1:0] wr_data,
  input  logic                    out_en_n,
  input  logic                    sleep,
  output logic [LANES*LANE_W-1:0] rd_data,
  output logic                    rd_drive
);
  logic              seq_load, seq_load_cpu, seq_sel_nx, seq_sel_q;
  logic [ADDR_W-1:0] seq_addr_nx, seq_cur_addr;
  logic [LANES-1:0]  dec_mask, wr_lanes;
  logic              rd_valid_q;

  bsr_addr_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst(rst), .addr_in(addr_in),
    .sel_n(sel_n), .sel_p(sel_p), .sel2_n(sel2_n),
    .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .step_n(step_n), .order_xor(order_xor), .sleep(sleep),
    .load(seq_load), .load_cpu(seq_load_cpu), .sel_nx(seq_sel_nx),
    .sel_q(seq_sel_q), .addr_nx(seq_addr_nx), .cur_addr(seq_cur_addr)
  );

  bsr_lane_decode #(.LANES(LANES)) u_dec (
    .all_wr_n(all_wr_n), .lane_wr_en_n(lane_wr_en_n),
    .lane_n(lane_n), .mask(dec_mask)
  );

  // a processor-strobe start is a read; nothing is written unless selected
  assign wr_lanes = (seq_sel_nx && !sleep && !seq_load_cpu) ? dec_mask : '0;

  bsr_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
    .clk(clk), .addr(seq_addr_nx), .we(wr_lanes),
    .wd(wr_data), .rd(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) rd_valid_q <= 1'b0;
    else     rd_valid_q <= seq_sel_nx && !sleep && (wr_lanes == '0);
  end

  // output enable and sleep gate the drivers without waiting for a clock
  assign rd_drive = rd_valid_q && !out_en_n && !sleep;
endmodule

// File: rtl/bsr_checker.sv
module bsr_checker #(
  parameter int ADDR_W = 10,
  parameter int LANES  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              sleep,
  input logic              strobe_cpu_n,
  input logic              strobe_ctl_n,
  input logic              sel_n,
  input logic              step_n,
  input logic              order_xor,
  input logic              load,
  input logic              sel_q,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [LANES-1:0]  wr_lanes,
  input logic              rd_drive
);
  // R10: the array is never written while asleep
  a_r10_no_write_asleep: assert property (@(posedge clk) disable iff (rst)
    sleep |-> wr_lanes == '0);

  // R10: drivers stay off on the cycle sleep is released
  a_r10_wake_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(sleep) |-> !rd_drive);

  // R8: a processor-strobe start never writes
  a_r8_cpu_start_reads: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n && !sel_n) |-> wr_lanes == '0);

  // R2: a processor strobe without primary select leaves the burst address alone
  a_r2_cpu_ignored: assert property (@(posedge clk) disable iff (rst)
    (!strobe_cpu_n && sel_n && strobe_ctl_n && step_n && !sleep && $stable(order_xor))
    |=> $stable(cur_addr));

  // R6: no advance means the same address is accessed again
  a_r6_hold: assert property (@(posedge clk) disable iff (rst)
    (sel_q && step_n && !load && !sleep && $stable(order_xor)) |=> $stable(cur_addr));

  // R4: a linear advance adds one to the word offset modulo 4
  a_r4_linear_step: assert property (@(posedge clk) disable iff (rst)
    (sel_q && !step_n && !load && !sleep && !order_xor && $stable(order_xor))
    |=> cur_addr[1:0] == 2'($past(cur_addr[1:0]) + 2'd1));
endmodule

bind burst_sram bsr_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst(rst), .sleep(sleep),
  .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
  .sel_n(sel_n), .step_n(step_n), .order_xor(order_xor),
  .load(seq_load), .sel_q(seq_sel_q), .cur_addr(seq_cur_addr),
  .wr_lanes(wr_lanes), .rd_drive(rd_drive)
);

// File: tb/sim_burst_sram.sv
`timescale 1ns/1ps
module sim_burst_sram;
  localparam int AW    = 10;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          sel_n = 1'b1, sel_p = 1'b1, sel2_n = 1'b0;
  logic          strobe_cpu_n = 1'b1, strobe_ctl_n = 1'b1, step_n = 1'b1;
  logic          order_xor = 1'b0, all_wr_n = 1'b1, lane_wr_en_n = 1'b1;
  logic [3:0]    lane_n = 4'hF;
  logic [31:0]   wr_data = '0;
  logic          out_en_n = 1'b0, sleep = 1'b0;
  logic [31:0]   rd_data;
  logic          rd_drive;

  int vectors = 0, miscompares = 0;
  bit done = 0;

  // reference model state
  logic [31:0] ref_mem [DEPTH];
  logic [AW-3:0] m_hi = '0;
  logic [1:0]    m_s = '0, m_k = '0;
  bit            m_sel = 0, m_valid = 0;
  logic [31:0]   m_data = '0;

  burst_sram #(.ADDR_W(AW), .LANES(4), .LANE_W(8)) u0 (
    .clk(clk), .rst(rst), .addr_in(addr_in), .sel_n(sel_n), .sel_p(sel_p),
    .sel2_n(sel2_n), .strobe_cpu_n(strobe_cpu_n), .strobe_ctl_n(strobe_ctl_n),
    .step_n(step_n), .order_xor(order_xor), .all_wr_n(all_wr_n),
    .lane_wr_en_n(lane_wr_en_n), .lane_n(lane_n), .wr_data(wr_data),
    .out_en_n(out_en_n), .sleep(sleep), .rd_data(rd_data), .rd_drive(rd_drive)
  );

  always #10 clk = ~clk;

  function automatic logic [31:0] pat(input int a);
    return 32'h9E37_79B9 * (a + 1) ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [1:0] ofs(input logic [1:0] s, input logic [1:0] k, input logic x);
    return x ? (s ^ k) : 2'(s + k);
  endfunction

  // model of one rising edge, from the requirements
  task automatic model_edge();
    bit gc, gt;
    logic [3:0] m;
    int a;
    if (rst || sleep) begin
      m_sel = 0; m_valid = 0; return;        // R10, R11
    end
    gc = !strobe_cpu_n && !sel_n;            // R1, R2
    gt = !strobe_ctl_n && !gc;
    if (gc || gt) begin
      m_hi = addr_in[AW-1:2]; m_s = addr_in[1:0]; m_k = 2'd0;
      m_sel = !sel_n && sel_p && !sel2_n;    // R3
    end else if (m_sel && !step_n) m_k = m_k + 2'd1;  // R6
    if (gc) m = 4'h0;                        // R8
    else if (!all_wr_n) m = 4'hF;            // R7
    else if (!lane_wr_en_n) m = ~lane_n;
    else m = 4'h0;
    a = int'({m_hi, ofs(m_s, m_k, order_xor)});   // R4, R5
    if (m_sel)
      for (int i = 0; i < 4; i++)
        if (m[i]) ref_mem[a][i*8 +: 8] = wr_data[i*8 +: 8];
    m_valid = m_sel && (m == 4'h0);
    m_data  = ref_mem[a];
  endtask

  task automatic check(input string tag);
    logic exp_drv;
    exp_drv = m_valid && !out_en_n && !sleep;
    vectors++;
    if (rd_drive !== exp_drv) begin
      miscompares++;
      $display("FAIL %s rd_drive actual %b expected %b at %0t", tag, rd_drive, exp_drv, $time);
    end else if (exp_drv && rd_data !== m_data) begin
      miscompares++;
      $display("FAIL %s rd_data actual %h expected %h at %0t", tag, rd_data, m_data, $time);
    end
  endtask

  // one clock: inputs are held, model follows the edge, outputs sampled at negedge
  task automatic cyc(input string tag);
    model_edge();
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle();
    strobe_cpu_n = 1; strobe_ctl_n = 1; step_n = 1;
    all_wr_n = 1; lane_wr_en_n = 1; lane_n = 4'hF;
  endtask

  task automatic burst_read(input int base, input logic x, input string tag);
    idle(); order_xor = x; sel_n = 0; sel_p = 1; sel2_n = 0;
    addr_in = AW'(base); strobe_cpu_n = 0;
    cyc(tag);
    strobe_cpu_n = 1; step_n = 0;
    for (int k = 1; k < 4; k++) cyc(tag);
    idle();
  endtask

  task automatic expect_word(input int a, input string tag);
    vectors++;
    if (!(rd_drive === 1'b1 && rd_data === pat(a))) begin
      miscompares++;
      $display("FAIL %s word actual %h/%b expected %h/1", tag, rd_data, rd_drive, pat(a));
    end
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst = 1;
    model_edge(); @(posedge clk); @(negedge clk);
    rst = 0;
    check("R11");

    // fill the array through controller-strobe global writes
    sel_n = 0; sel_p = 1; sel2_n = 0;
    for (int a = 0; a < DEPTH; a++) begin
      idle(); addr_in = AW'(a); strobe_ctl_n = 0; all_wr_n = 0; wr_data = pat(a);
      cyc("R7");
    end
    idle();

    // linear and interleaved bursts from every start offset, checked against fixed words
    for (int x = 0; x < 2; x++)
      for (int s = 0; s < 4; s++) begin
        idle(); order_xor = x[0]; addr_in = AW'(64 + s); strobe_cpu_n = 0;
        cyc("R1");
        expect_word(64 + s, "R1");
        strobe_cpu_n = 1; step_n = 0;
        for (int k = 1; k < 4; k++) begin
          cyc(x ? "R5" : "R4");
          expect_word(64 + int'(ofs(2'(s), 2'(k), x[0])), x ? "R5" : "R4");
        end
        idle();
      end

    // stall mid-burst, then an ignored processor strobe, then resume
    idle(); order_xor = 0; addr_in = AW'(130); strobe_cpu_n = 0; cyc("R1");
    strobe_cpu_n = 1; step_n = 0; cyc("R4");
    step_n = 1; cyc("R6"); expect_word(131, "R6");
    cyc("R6"); expect_word(131, "R6");
    sel_n = 1; strobe_cpu_n = 0; addr_in = AW'(500); cyc("R2"); expect_word(131, "R2");
    sel_n = 0; strobe_cpu_n = 1; step_n = 0; cyc("R4"); expect_word(128, "R4");
    idle();

    // deselected controller write must not land
    sel_p = 0; addr_in = AW'(200); strobe_ctl_n = 0; all_wr_n = 0; wr_data = 32'hDEAD_BEEF;
    cyc("R3");
    sel_p = 1; sel2_n = 1; addr_in = AW'(200); cyc("R3");
    sel2_n = 0; idle(); burst_read(200, 0, "R3"); idle();
    addr_in = AW'(200); strobe_cpu_n = 0; cyc("R3"); expect_word(200, "R3"); idle();

    // partial lane writes, then global write overriding lane enables
    addr_in = AW'(300); strobe_ctl_n = 0; lane_wr_en_n = 0; lane_n = 4'b1010;
    wr_data = 32'h1122_3344; cyc("R7");
    strobe_ctl_n = 1; step_n = 0; lane_n = 4'b0101; wr_data = 32'hAABB_CCDD; cyc("R7");
    idle(); burst_read(300, 0, "R7");
    addr_in = AW'(304); strobe_ctl_n = 0; all_wr_n = 0; lane_wr_en_n = 0; lane_n = 4'hF;
    wr_data = 32'h0F0F_F0F0; cyc("R7"); idle(); burst_read(304, 1, "R7");

    // processor-strobe start with write inputs active is a read
    addr_in = AW'(400); strobe_cpu_n = 0; all_wr_n = 0; wr_data = 32'h7777_7777;
    cyc("R8"); expect_word(400, "R8"); idle();

    // asynchronous output enable inside a burst
    addr_in = AW'(410); strobe_cpu_n = 0; cyc("R9"); strobe_cpu_n = 1;
    #2 out_en_n = 1; #1 check("R9");
    #1 out_en_n = 0; #1 check("R9");
    @(negedge clk); idle();

    // sleep: deselect, sleep with write attempts, wake with bus off
    sel_p = 0; addr_in = AW'(420); strobe_ctl_n = 0; cyc("R10"); idle(); sel_p = 1;
    sleep = 1;
    for (int i = 0; i < 3; i++) begin
      addr_in = AW'(420); strobe_ctl_n = 0; all_wr_n = 0; wr_data = 32'h1357_9BDF;
      cyc("R10");
    end
    idle(); sleep = 0; cyc("R10"); cyc("R10");
    addr_in = AW'(420); strobe_cpu_n = 0; cyc("R10"); expect_word(420, "R10"); idle();

    // constrained random traffic
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom % 100);
      addr_in      = AW'($urandom);
      sel_n        = ($urandom % 8) == 0;
      sel_p        = ($urandom % 10) != 0;
      sel2_n       = ($urandom % 10) == 0;
      strobe_cpu_n = !(r < 15);
      strobe_ctl_n = !(r >= 15 && r < 30);
      step_n       = ($urandom % 3) == 0;
      order_xor    = ($urandom % 4) == 0 ? ~order_xor : order_xor;
      all_wr_n     = ($urandom % 6) != 0;
      lane_wr_en_n = ($urandom % 4) != 0;
      lane_n       = 4'($urandom);
      wr_data      = $urandom;
      out_en_n     = ($urandom % 8) == 0;
      sleep        = ($urandom % 50) == 0;
      cyc("R1");
    end
    idle(); sleep = 0;
    cyc("R1");
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule